// File: doc/BRIEF.md
# Twisted-Pair Link Integrity Keeper

This block keeps a 10 Mb/s twisted-pair port's link alive and watches the partner's link. While the local transmitter is idle it emits a short link-integrity pulse at a fixed interval. Any transmit activity stops the pulse train and restarts the interval, so the first idle pulse after a frame comes one full interval after transmission ends.

On the receive side it watches for incoming link pulses and received packets. If neither arrives within a loss window, the link-good flag drops. It rises again only after a set number of link pulses has arrived. Packets keep a good link alive but cannot bring a lost link back.

The link-good flag gates the enables for the transmit path, the receive path and collision detection. All timing runs on a prescaled tick taken from the core clock. The tick divider is a parameter, so the default timing stays short enough for simulation.

Top module: `tp_link_keeper`

## Requirements
- R1: During and right after reset, `link_good`, `lp_out` and all three path enables are 0.
- R2: Each emitted link pulse holds `lp_out` high for exactly PULSE_CYC clock cycles, unless transmit activity cuts it short.
- R3: While `tx_active` stays low, rising edges of `lp_out` are exactly INTERVAL_TICKS*TICK_DIV clock cycles apart.
- R4: In the cycle after any clock edge that samples `tx_active` high, `lp_out` is 0.
- R5: The first pulse after reset release, or after `tx_active` falls, rises INTERVAL_TICKS*TICK_DIV clock edges after the last edge that sampled reset or `tx_active` high.
- R6: With the link good, `link_good` falls between (LOSS_TICKS-1)*TICK_DIV+1 and LOSS_TICKS*TICK_DIV edges after the last edge that sampled `lp_rx` or `rx_packet` high.
- R7: A one-cycle `rx_packet` or `lp_rx` restarts the loss window, so a good link with such activity at least every (LOSS_TICKS-1)*TICK_DIV cycles stays up.
- R8: With the link lost, `link_good` rises on the edge that samples the RESTORE_PULSES-th `lp_rx` strobe. `rx_packet` alone never raises it.
- R9: `tx_path_en` and `rx_path_en` equal `link_good`. `col_det_en` is `link_good` AND `tx_active`.
- R10: While the link is lost, restore strobes gathered so far are discarded when a full loss window passes with no activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous reset, active high |
| tx_active | input | 1 | Local transmitter is sending data |
| lp_rx | input | 1 | One-cycle strobe per valid received link pulse |
| rx_packet | input | 1 | Received packet activity |
| lp_out | output | 1 | Link pulse drive to the line driver |
| link_good | output | 1 | Partner link considered intact |
| tx_path_en | output | 1 | Transmit path enable |
| rx_path_en | output | 1 | Receive path enable |
| col_det_en | output | 1 | Collision detection enable |

## Verification
The pulse generator is run in three settings: a free-running idle train after reset, a train broken by a transmit burst, and the first pulse after that burst. The first shows the period and width. The second shows that transmission silences and restarts the timer, not merely pausing it. The third pins down where the interval starts. The link monitor is driven with link pulses alone, with packets alone, and with long silences. This shows which inputs keep a link up, which can restore it, and that a stale partial restore count does not carry over.

// File: rtl/tp_link_pkg.sv
package tp_link_pkg;

  // advance a modulo counter that wraps after reaching last
  function automatic logic [31:0] wrap_inc(input logic [31:0] cur, input logic [31:0] last);
    return (cur == last) ? 32'd0 : cur + 32'd1;
  endfunction

  // advance a counter that stops at its limit
  function automatic logic [31:0] sat_inc(input logic [31:0] cur, input logic [31:0] lim);
    return (cur >= lim) ? lim : cur + 32'd1;
  endfunction

  // clock cycles covered by a number of prescaled ticks
  function automatic int unsigned ticks_to_cycles(input int unsigned ticks, input int unsigned div);
    return ticks * div;
  endfunction

endpackage

// File: rtl/tp_tick_gen.sv
module tp_tick_gen #(
  parameter int unsigned TICK_DIV = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  output logic tick
);
  import tp_link_pkg::*;

  localparam int unsigned CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

  logic [CW-1:0] cnt;

  assign tick = !clr && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else            cnt <= CW'(wrap_inc(32'(cnt), 32'(TICK_DIV - 1)));
  end

endmodule

// File: rtl/tp_pulse_sched.sv
module tp_pulse_sched #(
  parameter int unsigned INTERVAL_TICKS = 16,
  parameter int unsigned PULSE_CYC      = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic tx_active,
  input  logic tick,
  output logic lp_out
);
  import tp_link_pkg::*;

  localparam int unsigned IW = (INTERVAL_TICKS > 1) ? $clog2(INTERVAL_TICKS) : 1;
  localparam int unsigned PW = $clog2(PULSE_CYC + 1);
  localparam logic [IW-1:0] IVL_LAST = IW'(INTERVAL_TICKS - 1);

  logic [IW-1:0] ivl;
  logic [PW-1:0] wcnt;
  logic          fire;

  assign fire   = tick && !tx_active && (ivl == IVL_LAST);
  assign lp_out = (wcnt != '0);

  always_ff @(posedge clk) begin
    if (rst || tx_active) begin
      ivl  <= '0;
      wcnt <= '0;
    end else begin
      if (tick) ivl <= IW'(wrap_inc(32'(ivl), 32'(INTERVAL_TICKS - 1)));
      if (fire)              wcnt <= PW'(PULSE_CYC);
      else if (wcnt != '0)   wcnt <= wcnt - 1'b1;
    end
  end

  // observation counter for the pulse width check
  logic [PW:0] run_len;
  always_ff @(posedge clk) begin
    if (rst)          run_len <= '0;
    else if (lp_out)  run_len <= run_len + 1'b1;
    else              run_len <= '0;
  end

  p_quiet_tx_r4: assert property (@(posedge clk) disable iff (rst)
    tx_active |=> !lp_out);

  p_width_cap_r2: assert property (@(posedge clk) disable iff (rst)
    run_len <= (PW+1)'(PULSE_CYC));

  p_pulse_start_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(lp_out) |-> $past(tick));

endmodule

// File: rtl/tp_link_watch.sv
module tp_link_watch #(
  parameter int unsigned LOSS_TICKS     = 100,
  parameter int unsigned RESTORE_PULSES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic lp_rx,
  input  logic rx_packet,
  output logic link_good
);
  import tp_link_pkg::*;

  localparam int unsigned SW = $clog2(LOSS_TICKS + 1);
  localparam int unsigned RW = (RESTORE_PULSES > 1) ? $clog2(RESTORE_PULSES) : 1;
  localparam logic [SW-1:0] SIL_LAST = SW'(LOSS_TICKS - 1);
  localparam logic [RW-1:0] RC_LAST  = RW'(RESTORE_PULSES - 1);

  logic [SW-1:0] sil;
  logic [RW-1:0] rcnt;
  logic          activity;
  logic          expire;
  logic          loss_evt;
  logic          restore_evt;

  assign activity    = lp_rx || rx_packet;
  assign expire      = tick && !activity && (sil == SIL_LAST);
  assign loss_evt    = expire && link_good;
  assign restore_evt = !link_good && lp_rx && (rcnt == RC_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      sil       <= '0;
      rcnt      <= '0;
      link_good <= 1'b0;
    end else begin
      if (activity)  sil <= '0;
      else if (tick) sil <= SW'(sat_inc(32'(sil), 32'(LOSS_TICKS)));

      if (loss_evt)         link_good <= 1'b0;
      else if (restore_evt) link_good <= 1'b1;

      if (link_good)        rcnt <= '0;
      else if (restore_evt) rcnt <= '0;
      else if (lp_rx)       rcnt <= rcnt + 1'b1;
      else if (expire)      rcnt <= '0;
    end
  end

  p_keepalive_r7: assert property (@(posedge clk) disable iff (rst)
    (link_good && activity) |=> link_good);

  p_loss_silent_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(link_good) |-> (!$past(lp_rx) && !$past(rx_packet)));

  p_restore_by_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(link_good) |-> $past(lp_rx));

  p_pkt_no_restore_r8: assert property (@(posedge clk) disable iff (rst)
    (!link_good && !lp_rx) |=> !link_good);

endmodule

// File: rtl/tp_link_keeper.sv
module tp_link_keeper #(
  parameter int unsigned TICK_DIV       = 8,
  parameter int unsigned INTERVAL_TICKS = 16,
  parameter int unsigned PULSE_CYC      = 10,
  parameter int unsigned LOSS_TICKS     = 100,
  parameter int unsigned RESTORE_PULSES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tx_active,
  input  logic lp_rx,
  input  logic rx_packet,
  output logic lp_out,
  output logic link_good,
  output logic tx_path_en,
  output logic rx_path_en,
  output logic col_det_en
);

  logic tx_tick;
  logic mon_tick;

  // pulse timer prescaler restarts with every transmit burst
  tp_tick_gen #(.TICK_DIV(TICK_DIV)) u_tx_tick (
    .clk(clk), .rst(rst), .clr(tx_active), .tick(tx_tick)
  );

  // loss monitor prescaler runs freely
  tp_tick_gen #(.TICK_DIV(TICK_DIV)) u_mon_tick (
    .clk(clk), .rst(rst), .clr(1'b0), .tick(mon_tick)
  );

  tp_pulse_sched #(
    .INTERVAL_TICKS(INTERVAL_TICKS), .PULSE_CYC(PULSE_CYC)
  ) u_sched (
    .clk(clk), .rst(rst), .tx_active(tx_active), .tick(tx_tick), .lp_out(lp_out)
  );

  tp_link_watch #(
    .LOSS_TICKS(LOSS_TICKS), .RESTORE_PULSES(RESTORE_PULSES)
  ) u_watch (
    .clk(clk), .rst(rst), .tick(mon_tick), .lp_rx(lp_rx), .rx_packet(rx_packet),
    .link_good(link_good)
  );

  assign tx_path_en = link_good;
  assign rx_path_en = link_good;
  assign col_det_en = link_good && tx_active;

  p_col_needs_tx_r9: assert property (@(posedge clk) disable iff (rst)
    col_det_en |-> (tx_active && tx_path_en));

  p_down_gates_r9: assert property (@(posedge clk) disable iff (rst)
    !link_good |-> (!tx_path_en && !rx_path_en && !col_det_en));

endmodule

// File: tb/tp_link_keeper_bench.sv
module tp_link_keeper_bench;

  localparam int DIV  = 8;
  localparam int IVT  = 16;
  localparam int PCYC = 10;
  localparam int LOSS = 100;
  localparam int NRST = 2;
  localparam int GAP  = IVT * DIV;

  logic clk = 1'b0;
  logic rst, tx_active, lp_rx, rx_packet;
  logic lp_out, link_good, tx_path_en, rx_path_en, col_det_en;

  always #4 clk = ~clk;

  tp_link_keeper #(
    .TICK_DIV(DIV), .INTERVAL_TICKS(IVT), .PULSE_CYC(PCYC),
    .LOSS_TICKS(LOSS), .RESTORE_PULSES(NRST)
  ) u_tp_link_keeper (
    .clk(clk), .rst(rst), .tx_active(tx_active), .lp_rx(lp_rx), .rx_packet(rx_packet),
    .lp_out(lp_out), .link_good(link_good), .tx_path_en(tx_path_en),
    .rx_path_en(rx_path_en), .col_det_en(col_det_en)
  );

  int checks = 0;
  int fails  = 0;
  int exp_gap[$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pulse_lp();
    #1 lp_rx = 1'b1;
    @(negedge clk);
    #1 lp_rx = 1'b0;
  endtask

  task automatic pulse_pkt();
    #1 rx_packet = 1'b1;
    @(negedge clk);
    #1 rx_packet = 1'b0;
  endtask

  // monitor: pops expected pulse gaps, checks width and tx silence
  int  since = 0;
  int  run   = 0;
  int  e_gap = 0;
  bit  prev  = 1'b0;
  bit  cut   = 1'b0;
  bit  from_q = 1'b0;
  initial begin
    forever begin
      @(negedge clk);
      since++;
      if (lp_out && !prev) begin
        from_q = (exp_gap.size() > 0);
        e_gap  = from_q ? exp_gap.pop_front() : GAP;
        if (from_q) chk(since == e_gap, "R5 first pulse delay", since, e_gap);
        else        chk(since == e_gap, "R3 pulse period", since, e_gap);
        since = 0;
        cut   = 1'b0;
      end
      if (lp_out) run++;
      if (!lp_out && prev) begin
        if (!cut) chk(run == PCYC, "R2 pulse width", run, PCYC);
        run = 0;
      end
      if (tx_active) begin
        cut = 1'b1;
        if (lp_out) chk(1'b0, "R4 pulse during tx", 1, 0);
      end
      if (tx_active || rst) since = 0;
      prev = lp_out;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst = 1'b1; tx_active = 1'b0; lp_rx = 1'b0; rx_packet = 1'b0;
    repeat (5) @(negedge clk);
    chk(link_good == 1'b0, "R1 link_good in reset", int'(link_good), 0);
    chk(lp_out == 1'b0, "R1 lp_out in reset", int'(lp_out), 0);
    chk({tx_path_en, rx_path_en, col_det_en} == 3'b000, "R1 enables in reset",
        int'({tx_path_en, rx_path_en, col_det_en}), 0);
    repeat (3) exp_gap.push_back(GAP);
    #1 rst = 1'b0;
    @(negedge clk);
    chk(link_good == 1'b0, "R1 link_good after reset", int'(link_good), 0);
    repeat (3 * GAP + 20) @(negedge clk);
    chk(exp_gap.size() == 0, "R5 reset pulses seen", exp_gap.size(), 0);

    // bring the link up with link pulses
    pulse_lp();
    chk(link_good == 1'b0, "R8 one pulse not enough", int'(link_good), 0);
    repeat (3) @(negedge clk);
    pulse_lp();
    chk(link_good == 1'b1, "R8 restore after pulses", int'(link_good), 1);
    chk(tx_path_en && rx_path_en, "R9 paths enabled", int'({tx_path_en, rx_path_en}), 3);
    chk(col_det_en == 1'b0, "R9 col off when idle", int'(col_det_en), 0);

    // transmit burst
    #1 tx_active = 1'b1;
    repeat (2) @(negedge clk);
    chk(col_det_en == 1'b1, "R9 col on during tx", int'(col_det_en), 1);
    repeat (48) @(negedge clk);
    exp_gap.push_back(GAP);
    #1 tx_active = 1'b0;
    @(negedge clk);
    chk(col_det_en == 1'b0, "R9 col off after tx", int'(col_det_en), 0);
    repeat (GAP + 10) @(negedge clk);
    chk(exp_gap.size() == 0, "R5 pulse after tx", exp_gap.size(), 0);

    // packets keep the link alive
    for (int i = 0; i < 4; i++) begin
      repeat (500) @(negedge clk);
      pulse_pkt();
      chk(link_good == 1'b1, "R7 packet keepalive", int'(link_good), 1);
    end

    // silence drops the link
    repeat ((LOSS - 1) * DIV) @(negedge clk);
    chk(link_good == 1'b1, "R6 still good before window", int'(link_good), 1);
    repeat (DIV) @(negedge clk);
    chk(link_good == 1'b0, "R6 lost after window", int'(link_good), 0);
    chk({tx_path_en, rx_path_en} == 2'b00, "R9 paths off when lost",
        int'({tx_path_en, rx_path_en}), 0);

    // packets alone do not restore
    for (int i = 0; i < 3; i++) begin
      pulse_pkt();
      repeat (5) @(negedge clk);
    end
    chk(link_good == 1'b0, "R8 packets do not restore", int'(link_good), 0);

    // partial restore count discarded after a silent window
    pulse_lp();
    repeat (LOSS * DIV + 2 * DIV) @(negedge clk);
    pulse_lp();
    chk(link_good == 1'b0, "R10 stale pulse discarded", int'(link_good), 0);
    repeat (3) @(negedge clk);
    pulse_lp();
    chk(link_good == 1'b1, "R10 restore after fresh pulses", int'(link_good), 1);

    repeat (5) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule